// File: doc/BRIEF.md
# Fractional-N Feedback Divider Control

This block is the digital heart of a fractional-N feedback divider. Its clock is the output of a dual-modulus prescaler, so each of its clock cycles is one prescaler output period. It counts those periods into division intervals of `B` cycles. It issues a one-cycle feedback pulse at the end of each interval. It also drives the modulus-select line that holds the prescaler at its larger ratio `P+1` for the first `S` cycles of the interval. Each interval therefore spans `P*B + S` input (oscillator) cycles.

The base swallow count `S = A` gives the integer ratio `N = P*B + A`. A fractional accumulator adds the numerator at every feedback pulse. Its modulus is selectable as 15 or 16. Whenever the sum wraps past the modulus, the following interval swallows one extra cycle. Over a full accumulator period of `M` intervals, the average ratio is then `N + k/M`. A separate select chooses a 16/17 or a 32/33 prescaler. The enable input holds the whole divider in a cleared, idle state while it is low.

Top module: `frac_n_div`

## Requirements
- R1: While enabled, `fb_pulse_o` is high for exactly one cycle in every `B` cycles, and that cycle is the last cycle of the interval.
- R2: In each interval, `modsel_o` is high for the first `S` cycles and low for the rest. `S` is `A_eff+1` when the accumulation at the end of the previous interval wrapped, and `A_eff` otherwise.
- R3: With numerator 0, every interval swallows exactly `A_eff` cycles, so every interval spans `P*B + A_eff` input cycles.
- R4: Take any `M` consecutive intervals after the first interval following enable. Their total input-cycle count (`P` per cycle, plus 1 for each cycle with `modsel_o` high) equals `M*(P*B+A_eff) + k_eff`.
- R5: `mod15_i = 1` selects accumulator modulus `M = 15`. `mod15_i = 0` selects `M = 16`.
- R6: `psel_i = 0` selects `P = 16` and limits the swallow count to 15 (`A_eff = min(A,15)`). `psel_i = 1` selects `P = 32` and accepts A up to 31.
- R7: A numerator `k` at or above `M` is treated as `M-1` (`k_eff`). Otherwise `k_eff = k`.
- R8: The denominators 1, 2, 3, 4, 5, 8, 15 and 16 are all reachable. For `d = M/gcd(k,M)`, any `d` consecutive intervals after the first one contain exactly `d*k/M` stretched intervals.
- R9: While `en_i` is low, both outputs stay low and the interval counter, accumulator and pending carry are cleared. After re-enable, the first interval lasts `B` cycles and swallows `A_eff`.
- R10: After reset with `en_i` low, both outputs are low. The first interval after enable lasts `B` cycles with swallow `A_eff`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaler output clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Divider enable; low holds the divider cleared |
| b_i | input | B_W (10) | Interval length B in prescaler cycles, at least A_eff+1 |
| a_i | input | A_W (5) | Base swallow count A |
| num_i | input | F_W (4) | Fractional numerator k |
| mod15_i | input | 1 | 1: accumulator modulus 15, 0: modulus 16 |
| psel_i | input | 1 | 1: 32/33 prescaler, 0: 16/17 prescaler |
| modsel_o | output | 1 | High selects the prescaler ratio P+1 |
| fb_pulse_o | output | 1 | One-cycle pulse at the end of each interval |

## Verification
The bench chases the clamps first. A 16/17 setting with A above 15, or a numerator of 15 under modulus 15, would stretch the ratio beyond its legal range and break the period total. Each listed denominator is checked over a window of its own length, so a wrap compare of `>` instead of `>=`, or a modulus decode that is off by one, shows up as a wrong count of stretched intervals. A disable is forced while a carry is pending and the counter is mid-interval. A divider that failed to clear either one would open with a short interval or an extra swallow.

// File: rtl/fnd_pkg.sv
`timescale 1ns/1ps
package fnd_pkg;
  localparam int unsigned B_W_DEF = 10;
  localparam int unsigned A_W_DEF = 5;
  localparam int unsigned F_W_DEF = 4;

  typedef enum logic {MOD_16 = 1'b0, MOD_15 = 1'b1} fmod_e;
  typedef enum logic {PS_16 = 1'b0, PS_32 = 1'b1} psize_e;
endpackage

// File: rtl/fnd_cfg.sv
`timescale 1ns/1ps
module fnd_cfg
  import fnd_pkg::*;
#(
  parameter int unsigned A_W = A_W_DEF,
  parameter int unsigned F_W = F_W_DEF
) (
  input  logic [A_W-1:0] a_i,
  input  logic [F_W-1:0] num_i,
  input  logic           mod15_i,
  input  logic           psel_i,
  output logic [A_W-1:0] a_eff_o,
  output logic [F_W-1:0] num_eff_o,
  output logic [F_W:0]   modv_o
);
  // small prescaler accepts half the swallow range
  localparam logic [A_W-1:0] A_LIM_S   = A_W'((1 << (A_W-1)) - 1);
  localparam logic [F_W:0]   MODV_FULL = (F_W+1)'(1 << F_W);

  logic [F_W:0] modv;

  always_comb begin
    modv    = (mod15_i == MOD_15) ? MODV_FULL - 1'b1 : MODV_FULL;
    modv_o  = modv;
    a_eff_o = (psel_i == PS_32 || a_i <= A_LIM_S) ? a_i : A_LIM_S;
    num_eff_o = ({1'b0, num_i} >= modv) ? F_W'(modv - 1'b1) : num_i;
  end
endmodule

// File: rtl/fnd_acc.sv
`timescale 1ns/1ps
module fnd_acc
  import fnd_pkg::*;
#(
  parameter int unsigned F_W = F_W_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           step_i,
  input  logic [F_W-1:0] num_i,
  input  logic [F_W:0]   modv_i,
  output logic           carry_o
);
  logic [F_W-1:0] acc_q;
  logic           carry_q;
  logic [F_W:0]   sum;
  logic           wrap;

  always_comb begin
    sum  = {1'b0, acc_q} + {1'b0, num_i};
    wrap = (sum >= modv_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (clr_i) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (step_i) begin
      acc_q   <= wrap ? F_W'(sum - modv_i) : F_W'(sum);
      carry_q <= wrap;
    end
  end

  assign carry_o = carry_q;

  a_r5_acc_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, acc_q} < modv_i);
  a_r9_acc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0) && !carry_q);
endmodule

// File: rtl/fnd_swc.sv
`timescale 1ns/1ps
module fnd_swc
  import fnd_pkg::*;
#(
  parameter int unsigned B_W = B_W_DEF,
  parameter int unsigned A_W = A_W_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [B_W-1:0] b_i,
  input  logic [A_W-1:0] a_i,
  input  logic           carry_i,
  output logic           modsel_o,
  output logic           pulse_o
);
  logic [B_W-1:0] cnt_q;
  logic [A_W:0]   swl_raw;
  logic [B_W-1:0] swl;

  always_comb begin
    swl_raw  = {1'b0, a_i} + {{A_W{1'b0}}, carry_i};
    swl      = (B_W'(swl_raw) > b_i) ? b_i : B_W'(swl_raw);
    modsel_o = en_i && (cnt_q < swl);
    pulse_o  = en_i && (cnt_q == b_i - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (pulse_o)  cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !pulse_o) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r9_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/frac_n_div.sv
`timescale 1ns/1ps
module frac_n_div
  import fnd_pkg::*;
#(
  parameter int unsigned B_W = B_W_DEF,
  parameter int unsigned A_W = A_W_DEF,
  parameter int unsigned F_W = F_W_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [B_W-1:0] b_i,
  input  logic [A_W-1:0] a_i,
  input  logic [F_W-1:0] num_i,
  input  logic           mod15_i,
  input  logic           psel_i,
  output logic           modsel_o,
  output logic           fb_pulse_o
);
  logic [A_W-1:0] a_eff;
  logic [F_W-1:0] num_eff;
  logic [F_W:0]   modv;
  logic           carry;
  logic           pulse;

  fnd_cfg #(.A_W(A_W), .F_W(F_W)) i_cfg (
    .a_i      (a_i),
    .num_i    (num_i),
    .mod15_i  (mod15_i),
    .psel_i   (psel_i),
    .a_eff_o  (a_eff),
    .num_eff_o(num_eff),
    .modv_o   (modv)
  );

  fnd_acc #(.F_W(F_W)) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!en_i),
    .step_i (pulse),
    .num_i  (num_eff),
    .modv_i (modv),
    .carry_o(carry)
  );

  fnd_swc #(.B_W(B_W), .A_W(A_W)) i_swc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .b_i     (b_i),
    .a_i     (a_eff),
    .carry_i (carry),
    .modsel_o(modsel_o),
    .pulse_o (pulse)
  );

  assign fb_pulse_o = pulse;

  a_r7_num_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, num_eff} < modv);
  a_r9_idle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !modsel_o && !fb_pulse_o);
endmodule

// File: tb/test_frac_n_div.sv
`timescale 1ns/1ps
module test_frac_n_div;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [9:0] b_i = '0;
  logic [4:0] a_i = '0;
  logic [3:0] num_i = '0;
  logic       mod15_i = 1'b0;
  logic       psel_i = 1'b0;
  logic       modsel_o, fb_pulse_o;

  int n_chk = 0;
  int n_err = 0;
  int p_cur = 16;

  always #2 clk_i = ~clk_i;

  frac_n_div i_frac_n_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .b_i(b_i), .a_i(a_i),
    .num_i(num_i), .mod15_i(mod15_i), .psel_i(psel_i),
    .modsel_o(modsel_o), .fb_pulse_o(fb_pulse_o)
  );

  typedef struct packed {
    logic [9:0] b;
    logic [4:0] a;
    logic [3:0] num;
    logic       m15;
    logic       ps;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{10'd20, 5'd5,  4'd0,  1'b0, 1'b0},
    '{10'd20, 5'd5,  4'd1,  1'b0, 1'b1},
    '{10'd40, 5'd10, 4'd7,  1'b1, 1'b1},
    '{10'd17, 5'd3,  4'd15, 1'b0, 1'b0},
    '{10'd40, 5'd20, 4'd15, 1'b1, 1'b0},
    '{10'd50, 5'd31, 4'd9,  1'b0, 1'b1},
    '{10'd21, 5'd16, 4'd15, 1'b1, 1'b1}
  };

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // called positioned at a negedge; returns at the negedge after the pulse
  task automatic next_interval(output int ncyc, output int nsw, output int vco);
    int  guard = 0;
    bit  done = 0;
    ncyc = 0; nsw = 0; vco = 0;
    while (!done && guard < 4000) begin
      #1;
      ncyc++;
      nsw += int'(modsel_o);
      vco += p_cur + int'(modsel_o);
      done = fb_pulse_o;
      guard++;
      @(negedge clk_i);
    end
    if (!done) check(1'b0, "R1 no pulse", guard, -1);
  endtask

  task automatic setup(int b, int a, int k, bit m15, bit ps);
    @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    b_i = 10'(b); a_i = 5'(a); num_i = 4'(k); mod15_i = m15; psel_i = ps;
    p_cur = ps ? 32 : 16;
    @(negedge clk_i);
    en_i = 1'b1;
  endtask

  function automatic int gcd(int x, int y);
    int t;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int ncyc, nsw, vco;
    // R10 reset state
    repeat (3) @(negedge clk_i);
    #1;
    check(!modsel_o && !fb_pulse_o, "R10 outputs in reset", int'({modsel_o, fb_pulse_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    #1;
    check(!modsel_o && !fb_pulse_o, "R10 outputs after reset", int'({modsel_o, fb_pulse_o}), 0);

    // vector table: R1..R7
    for (int v = 0; v < NV; v++) begin
      int m, ke, ae, n, tot, str;
      bit ok_len, ok_sw;
      m  = VECS[v].m15 ? 15 : 16;                               // R5
      ke = (int'(VECS[v].num) >= m) ? m - 1 : int'(VECS[v].num); // R7
      ae = (!VECS[v].ps && VECS[v].a > 15) ? 15 : int'(VECS[v].a); // R6
      n  = (VECS[v].ps ? 32 : 16) * int'(VECS[v].b) + ae;
      setup(int'(VECS[v].b), int'(VECS[v].a), int'(VECS[v].num), VECS[v].m15, VECS[v].ps);
      next_interval(ncyc, nsw, vco);
      check(ncyc == int'(VECS[v].b), "R10 first interval length", ncyc, int'(VECS[v].b));
      check(nsw == ae, "R6 first swallow", nsw, ae);
      tot = 0; str = 0; ok_len = 1; ok_sw = 1;
      for (int i = 0; i < m; i++) begin
        next_interval(ncyc, nsw, vco);
        tot += vco;
        if (ncyc != int'(VECS[v].b)) ok_len = 0;
        if (nsw == ae + 1) str++;
        else if (nsw != ae) ok_sw = 0;
      end
      check(ok_len, "R1 interval length", ncyc, int'(VECS[v].b));
      check(ok_sw, "R2 swallow per interval", nsw, ae);
      check(str == ke, "R2 stretched count", str, ke);
      check(tot == m * n + ke, "R4 period total", tot, m * n + ke);
      if (ke == 0) check(str == 0 && vco == n, "R3 integer interval", vco, n);
    end

    // R8 denominators
    for (int j = 0; j < 8; j++) begin
      int m, k, d, tot, str, n;
      case (j)
        0: begin m = 16; k = 0; end
        1: begin m = 16; k = 8; end
        2: begin m = 15; k = 5; end
        3: begin m = 16; k = 4; end
        4: begin m = 15; k = 3; end
        5: begin m = 16; k = 2; end
        6: begin m = 15; k = 1; end
        default: begin m = 16; k = 1; end
      endcase
      d = (k == 0) ? 1 : m / gcd(k, m);
      n = 16 * 20 + 4;
      setup(20, 4, k, m == 15, 1'b0);
      next_interval(ncyc, nsw, vco);
      tot = 0; str = 0;
      for (int i = 0; i < d; i++) begin
        next_interval(ncyc, nsw, vco);
        tot += vco;
        if (nsw == 5) str++;
      end
      check(str == d * k / m, "R8 stretched in window", str, d * k / m);
      check(tot == d * n + d * k / m, "R8 window total", tot, d * n + d * k / m);
    end

    // R9 disable with pending carry, mid-interval
    setup(12, 3, 8, 1'b0, 1'b0);
    next_interval(ncyc, nsw, vco);
    next_interval(ncyc, nsw, vco);
    repeat (3) @(negedge clk_i);
    en_i = 1'b0;
    begin
      bit quiet = 1;
      for (int i = 0; i < 4; i++) begin
        #1;
        if (modsel_o || fb_pulse_o) quiet = 0;
        @(negedge clk_i);
      end
      check(quiet, "R9 outputs low while disabled", 0, 1);
    end
    en_i = 1'b1;
    next_interval(ncyc, nsw, vco);
    check(ncyc == 12, "R9 first length after enable", ncyc, 12);
    check(nsw == 3, "R9 carry cleared", nsw, 3);
    next_interval(ncyc, nsw, vco);
    check(nsw == 3, "R9 accumulator cleared", nsw, 3);
    next_interval(ncyc, nsw, vco);
    check(nsw == 4, "R2 carry after wrap", nsw, 4);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule